// File: doc/BRIEF.md
# SPI Hold Pause Gate

This block sits between the serial pins of an SPI slave and its command sequencer, and it implements the hold pause. The block runs on a fast system clock, and the pin inputs reach it already synchronised. It samples the serial clock and detects rising and falling edges from the sampled value. It passes those edges to the sequencer as single-cycle strobes. The sampled data input goes out with them.

While the device is selected, a low hold pin pauses the bus. During the pause both edge strobes are suppressed and the data bit seen by the sequencer is frozen at its last value. The output enable for the tri-state data pin is also forced low. The sequencer keeps whatever partial instruction or page data it held, and it resumes when the pause ends.

Hold can only start or end while the sampled serial clock is low. A change on the hold pin that arrives while the clock is high waits for the next falling edge. Deselecting the device ends any pause, drops any waiting request and raises a clear level for the sequencer.

Top module: `spi_hold_gate`

## Requirements
- R1: While reset is asserted and immediately after it, hold_o, sdo_oe_o, sck_rise_o and sck_fall_o are 0 and cmd_clr_o is 1.
- R2: Every pin input is registered once on clk. sck_rise_o is 1 in a cycle where the registered clock is 1 and was 0 in the cycle before. sck_fall_o is 1 in a cycle where it is 0 and was 1 before. Each strobe is raised only when the registered chip select is 0 and hold_o is 0.
- R3: When the registered chip select is 0, the registered clock is 0 and the registered hold pin is 0, hold_o is 1 in the next cycle.
- R4: While the registered clock is 1, hold_o keeps its value. A hold request made while the clock is high therefore takes effect in the cycle after the registered clock is next seen at 0. The falling-edge strobe of that edge is still reported. If the hold pin returns high before that edge, no hold occurs.
- R5: When hold_o is 1 and the registered clock is 0 with the registered hold pin at 1, hold_o is 0 in the next cycle.
- R6: A release made while the clock is high waits for the next falling edge. The falling-edge strobe of that edge is suppressed.
- R7: While hold_o is 1, neither sck_rise_o nor sck_fall_o is raised.
- R8: sdo_oe_o equals core_oe_i only while the registered chip select is 0 and hold_o is 0. Otherwise it is 0.
- R9: While hold_o is 0, sdi_o equals the registered data input. While hold_o is 1, sdi_o holds the value the registered data input had in the last cycle before hold began.
- R10: A registered chip select of 1 forces hold_o to 0 in the next cycle and discards any deferred request. cmd_clr_o equals the registered chip select, so it is 1 while the device is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Synchronised serial clock pin |
| csn_i | input | 1 | Synchronised chip select, active low |
| holdn_i | input | 1 | Synchronised hold pin, active low |
| sdi_i | input | 1 | Synchronised serial data input |
| core_oe_i | input | 1 | Sequencer request to drive the data output |
| sck_rise_o | output | 1 | Qualified rising-edge strobe |
| sck_fall_o | output | 1 | Qualified falling-edge strobe |
| sdi_o | output | 1 | Data bit seen by the sequencer, frozen during hold |
| sdo_oe_o | output | 1 | Output enable for the tri-state data pin |
| hold_o | output | 1 | Hold pause in effect |
| cmd_clr_o | output | 1 | Sequencer clear level, high while deselected |

## Verification
The bench covers each of the four timing cases for the hold pin: entry and exit, each with the clock low and with the clock high. A design that ignored the clock level would enter or leave hold in the middle of a high phase. It would then swallow or duplicate the rising edge already counted. The bench also checks the falling edge that closes a deferred release, which must stay unreported. A gate that qualified strobes with the next hold value instead of the current one would emit a stray falling strobe there and shift the sequencer by one bit. Two further cases test cancellation: a hold request withdrawn before the falling edge, and a request cut off by deselection. A design that latched the request would enter hold late. Finally, the bench toggles the data input during a pause to catch a frozen bit that leaks through, and it asserts reset in the middle of a hold.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic holdn_i,
  input  logic sdi_i,
  input  logic core_oe_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sdi_o,
  output logic sdo_oe_o,
  output logic hold_o,
  output logic cmd_clr_o
);

  logic sck_q, sck_prev, csn_q, holdn_q, sdi_q;
  logic hold_q, sdi_frz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      sck_prev <= 1'b0;
      csn_q    <= 1'b1;
      holdn_q  <= 1'b1;
      sdi_q    <= 1'b0;
      hold_q   <= 1'b0;
      sdi_frz  <= 1'b0;
    end else begin
      sck_q    <= sck_i;
      sck_prev <= sck_q;
      csn_q    <= csn_i;
      holdn_q  <= holdn_i;
      sdi_q    <= sdi_i;
      if (csn_q)
        hold_q <= 1'b0;
      else if (!sck_q)
        hold_q <= !holdn_q;
      if (!hold_q)
        sdi_frz <= sdi_q;
    end
  end

  wire live = !csn_q && !hold_q;

  assign sck_rise_o = live && sck_q && !sck_prev;
  assign sck_fall_o = live && !sck_q && sck_prev;
  assign sdi_o      = hold_q ? sdi_frz : sdi_q;
  assign sdo_oe_o   = live && core_oe_i;
  assign hold_o     = hold_q;
  assign cmd_clr_o  = csn_q;

  AST_DESELECT_ENDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_o |=> !hold_o);  // R10

  AST_HIGH_CLOCK_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && !cmd_clr_o) |=> $stable(hold_o));  // R4

  AST_LOW_CLOCK_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_clr_o && !sck_q) |=> (hold_o == !$past(holdn_q)));  // R3

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && $past(hold_o)) |-> $stable(sdi_o));  // R9

  AST_SILENT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_o) && hold_o |-> !sdo_oe_o && !(sck_rise_o || sck_fall_o));  // R7

endmodule

// File: tb/sim_spi_hold_gate.sv
module sim_spi_hold_gate;
  localparam int PERIOD = 10;
  localparam int NV = 29;
  // {csn, holdn, sck, core_oe, exp_rise, exp_fall, exp_hold, exp_oe, exp_clr}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_1_0_1_0_0_0_1_0, 9'b0_1_1_1_1_0_0_1_0, 9'b0_1_0_1_0_1_0_1_0,
    9'b0_0_0_1_0_0_0_1_0, 9'b0_0_1_1_0_0_1_0_0, 9'b0_0_0_1_0_0_1_0_0,
    9'b0_1_0_1_0_0_1_0_0, 9'b0_1_1_1_1_0_0_1_0, 9'b0_0_1_1_0_0_0_1_0,
    9'b0_0_1_1_0_0_0_1_0, 9'b0_0_0_1_0_1_0_1_0, 9'b0_0_0_1_0_0_1_0_0,
    9'b0_0_1_1_0_0_1_0_0, 9'b0_1_1_1_0_0_1_0_0, 9'b0_1_1_1_0_0_1_0_0,
    9'b0_1_0_1_0_0_1_0_0, 9'b0_1_0_1_0_0_0_1_0, 9'b0_1_1_1_1_0_0_1_0,
    9'b0_0_0_1_0_1_0_1_0, 9'b0_0_1_1_0_0_1_0_0, 9'b1_0_1_1_0_0_1_0_1,
    9'b1_0_0_1_0_0_0_0_1, 9'b0_0_1_1_1_0_0_1_0, 9'b0_1_0_1_0_1_0_1_0,
    9'b0_1_1_0_1_0_0_0_0, 9'b0_0_1_1_0_0_0_1_0, 9'b1_0_1_1_0_0_0_0_1,
    9'b0_1_0_1_0_1_0_1_0, 9'b0_1_0_1_0_0_0_1_0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, holdn = 1'b1, sdi = 1'b0, coe = 1'b0;
  logic rise, fall, sdo_di, oe, hold, clr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  spi_hold_gate u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .holdn_i(holdn),
    .sdi_i(sdi), .core_oe_i(coe), .sck_rise_o(rise), .sck_fall_o(fall),
    .sdi_o(sdo_di), .sdo_oe_o(oe), .hold_o(hold), .cmd_clr_o(clr)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic h, input logic k, input logic d, input logic o);
    @(negedge clk);
    csn = c; holdn = h; sck = k; sdi = d; coe = o;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic frz, prev_c, prev_k, prev_h, prev_cs;
    string htag, stag;
    step(1, 1, 0, 0, 1);
    // R1: outputs during reset
    chk("R1", "hold", hold, 1'b0); chk("R1", "oe", oe, 1'b0);
    chk("R1", "clr", clr, 1'b1); chk("R1", "rise", rise, 1'b0);
    rst_n = 1'b1;
    step(1, 1, 0, 0, 1);
    chk("R1", "fall after reset", fall, 1'b0);
    chk("R1", "hold after reset", hold, 1'b0);

    frz = 1'b0; prev_c = 1'b1; prev_k = 1'b0; prev_h = 1'b1; prev_cs = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      logic d, ed;
      v = VEC[i];
      d = (i % 3 == 0);
      step(v[8], v[7], v[6], d, v[5]);
      if (prev_cs) htag = "R10";
      else if (prev_h) htag = prev_k ? "R6" : "R5";
      else htag = prev_k ? "R4" : "R3";
      stag = v[2] ? "R7" : "R2";
      chk(stag, "rise strobe", rise, v[4]);
      chk(stag, "fall strobe", fall, v[3]);
      chk(htag, "hold", hold, v[2]);
      chk("R8", "output enable", oe, v[1]);
      chk("R10", "clear", clr, v[0]);
      ed = v[2] ? frz : d;
      chk("R9", "data seen", sdo_di, ed);
      if (!v[2]) frz = d;
      prev_cs = v[8]; prev_k = v[6]; prev_h = v[2]; prev_c = v[7];
    end

    // R9: data toggles during hold leave sdi_o unchanged
    step(0, 1, 0, 1, 1);
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1);
    chk("R9", "frozen data", sdo_di, 1'b1);
    step(0, 0, 1, 0, 1);
    chk("R9", "frozen data on edge", sdo_di, 1'b1);
    chk("R7", "rise in hold", rise, 1'b0);

    // R1: reset during hold clears it
    @(negedge clk); rst_n = 1'b0;
    #(PERIOD/4);
    chk("R1", "hold under reset", hold, 1'b0);
    chk("R1", "oe under reset", oe, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 1, 0, 0, 1);
    chk("R1", "hold after mid-hold reset", hold, 1'b0);

    finish_run();
  end
endmodule